// File: doc/BRIEF.md
# Seven-to-one pixel lane serializer

This block turns one parallel pixel per pixel period into five serial data lanes and one clock lane, all running at seven times the pixel rate. Each pixel carries 10-bit red, green and blue values, a data-enable flag, horizontal and vertical sync, and two spare bits. These 35 bits are packed by a fixed mapping into five 7-bit lane words (lanes A to E). Each word is then shifted out one bit per fast-clock cycle.

The block runs entirely on the fast (7x) clock. An internal slot counter divides it by seven and raises `pix_take` for one fast cycle per pixel period. The upstream source holds a pixel valid on that edge, and the pixel is captured there. A clock lane repeats a fixed seven-slot pattern so that a receiver can find the frame boundary. The active-low `rst_n` doubles as power-down. While it is low, every serial output is held low and `lane_oe` is deasserted. Board logic is expected to use `lane_oe` as the tri-state enable of the line drivers.

Top module: `pixel_lane_serializer`

## Requirements
- R1: `pix_take` is high in exactly one fast cycle out of every seven. It is high in the first cycle after `rst_n` is released, and it is low while `rst_n` is low. The pixel inputs are sampled on the rising edge at which `pix_take` is high.
- R2: Lane A (`lane_out[0]`) carries the 7-bit word {green[4], red[9:4]}, listed from D6 down to D0.
- R3: Lane B (`lane_out[1]`) carries {blue[5:4], green[9:5]}, listed from D6 down to D0.
- R4: Lane C (`lane_out[2]`) carries {de, vsync, hsync, blue[9:6]}, listed from D6 down to D0.
- R5: Lane D (`lane_out[3]`) carries {spare[0], blue[3:2], green[3:2], red[3:2]}, listed from D6 down to D0.
- R6: Lane E (`lane_out[4]`) carries {spare[1], blue[1:0], green[1:0], red[1:0]}, listed from D6 down to D0.
- R7: D6 of a captured word appears on its lane in the cycle right after the capture edge. D5 to D0 follow, one per fast cycle, so each word fills seven consecutive slots.
- R8: `clk_lane` outputs 1,1,0,0,0,1,1 over the seven slots of each pixel period, starting in the same slot as D6.
- R9: While `rst_n` is low at a clock edge, after that edge `lane_oe`, `clk_lane` and every lane are 0. The slot counter restarts, so the next capture happens in the first cycle after release.
- R10: `lane_oe` rises in the slot where the first word after reset appears. It then stays high until `rst_n` is next low.
- R11: Pixel input changes in cycles where `pix_take` is low have no effect on any serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, seven cycles per pixel |
| rst_n | input | 1 | Synchronous active-low reset and power-down |
| red | input | 10 | Red component |
| green | input | 10 | Green component |
| blue | input | 10 | Blue component |
| de | input | 1 | Data-enable flag |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| spare | input | 2 | Two spare data bits |
| pix_take | output | 1 | Capture strobe: pixel inputs sampled on this cycle's edge |
| lane_out | output | 5 | Serial data lanes, bit 0 is lane A through bit 4 lane E |
| clk_lane | output | 1 | Serial clock-lane pattern |
| lane_oe | output | 1 | Output enable for the serial line drivers |

## Verification
The bench builds the block with its default parameters: first-slot-is-D6 shift order and the 1100011 clock-lane pattern. This exposes every mapping position and the frame alignment that receivers depend on. Inputs change on every fast cycle, including the six cycles between captures, so only the sampled pixel may reach the lanes. A walking-one pass over all 35 input bits puts each bit into exactly one lane and slot. A power-down in the middle of a frame exercises the restart of the slot counter and the re-raising of the enable.

// File: rtl/pls_pkg.sv
package pls_pkg;
   localparam int COLOR_W = 10;
   localparam int N_LANES = 5;
   localparam int SLOTS   = 7;
   localparam int CNT_W   = $clog2(SLOTS);

   typedef struct packed {
      logic [1:0]         spare;
      logic               vsync;
      logic               hsync;
      logic               de;
      logic [COLOR_W-1:0] blue;
      logic [COLOR_W-1:0] green;
      logic [COLOR_W-1:0] red;
   } pixel_t;

   typedef logic [N_LANES-1:0][SLOTS-1:0] lane_words_t;
endpackage

// File: rtl/pls_lane_mapper.sv
module pls_lane_mapper
   import pls_pkg::*;
(
   input  pixel_t      px,
   output lane_words_t words
);
   always_comb begin
      words[0] = {px.green[4], px.red[9:4]};
      words[1] = {px.blue[5:4], px.green[9:5]};
      words[2] = {px.de, px.vsync, px.hsync, px.blue[9:6]};
      words[3] = {px.spare[0], px.blue[3:2], px.green[3:2], px.red[3:2]};
      words[4] = {px.spare[1], px.blue[1:0], px.green[1:0], px.red[1:0]};
   end
endmodule

// File: rtl/pls_slot_timer.sv
module pls_slot_timer #(
   parameter int SLOTS = 7
) (
   input  logic clk,
   input  logic rst_n,
   output logic load,
   output logic oe
);
   localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

   logic [CNT_W-1:0] cnt;

   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("pls_slot_timer: SLOTS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         oe  <= 1'b0;
      end else begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         if (cnt == '0) oe <= 1'b1;
      end
   end

   assign load = rst_n && (cnt == '0);

   // R1: a capture strobe is never followed directly by another
   assert_take_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !load);
endmodule

// File: rtl/pls_lane_shifter.sv
module pls_lane_shifter #(
   parameter int SLOTS     = 7,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SLOTS-1:0] word,
   output logic             bit_out
);
   localparam int FIRST = MSB_FIRST ? SLOTS - 1 : 0;

   logic [SLOTS-1:0] sh;

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk) begin
            if (!rst_n)    sh <= '0;
            else if (load) sh <= word;
            else           sh <= {sh[SLOTS-2:0], 1'b0};
         end
         assign bit_out = sh[SLOTS-1];
      end else begin : g_lsb
         always_ff @(posedge clk) begin
            if (!rst_n)    sh <= '0;
            else if (load) sh <= word;
            else           sh <= {1'b0, sh[SLOTS-1:1]};
         end
         assign bit_out = sh[0];
      end
   endgenerate

   // R7: the first slot after a capture shows the first bit of the word
   assert_first_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (bit_out == $past(word[FIRST])));
endmodule

// File: rtl/pixel_lane_serializer.sv
module pixel_lane_serializer
   import pls_pkg::*;
#(
   parameter logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011,
   parameter bit               MSB_FIRST   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [COLOR_W-1:0] red,
   input  logic [COLOR_W-1:0] green,
   input  logic [COLOR_W-1:0] blue,
   input  logic               de,
   input  logic               hsync,
   input  logic               vsync,
   input  logic [1:0]         spare,
   output logic               pix_take,
   output logic [N_LANES-1:0] lane_out,
   output logic               clk_lane,
   output logic               lane_oe
);
   localparam int FIRST = MSB_FIRST ? SLOTS - 1 : 0;

   generate
      if ($countones(CLK_PATTERN) == 0 || $countones(CLK_PATTERN) == SLOTS) begin : g_bad_pat
         $error("pixel_lane_serializer: CLK_PATTERN needs both levels");
      end
   endgenerate

   pixel_t      px;
   lane_words_t words;
   logic        load;

   always_comb begin
      px.red   = red;
      px.green = green;
      px.blue  = blue;
      px.de    = de;
      px.hsync = hsync;
      px.vsync = vsync;
      px.spare = spare;
   end

   pls_lane_mapper u_map (
      .px    (px),
      .words (words)
   );

   pls_slot_timer #(.SLOTS(SLOTS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .oe    (lane_oe)
   );

   generate
      for (genvar i = 0; i < N_LANES; i++) begin : g_lane
         pls_lane_shifter #(.SLOTS(SLOTS), .MSB_FIRST(MSB_FIRST)) u_sh (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .word    (words[i]),
            .bit_out (lane_out[i])
         );
      end
   endgenerate

   pls_lane_shifter #(.SLOTS(SLOTS), .MSB_FIRST(MSB_FIRST)) u_clk_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .word    (CLK_PATTERN),
      .bit_out (clk_lane)
   );

   assign pix_take = load;

   // R9: a power-down edge leaves the enable low
   assert_pd_off_R9: assert property (@(posedge clk)
      !rst_n |=> !lane_oe);

   // R9: with the enable low, no serial output toggles
   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_oe |-> (lane_out == '0 && clk_lane == 1'b0));

   // R10: the enable only rises after a capture
   assert_oe_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lane_oe) |-> $past(pix_take));

   // R10: once up, the enable holds until reset
   assert_oe_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lane_oe |=> lane_oe);

   // R8: the clock lane starts each frame with the pattern's first slot
   assert_clk_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pix_take |=> (clk_lane == CLK_PATTERN[FIRST]));
endmodule

// File: tb/sim_pixel_lane_serializer.sv
`timescale 1ns/1ps
module sim_pixel_lane_serializer;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic [34:0] vin = '0;
   logic        pix_take, clk_lane, lane_oe;
   logic [4:0]  lane_out;

   pixel_lane_serializer u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .red      (vin[9:0]),
      .green    (vin[19:10]),
      .blue     (vin[29:20]),
      .de       (vin[30]),
      .hsync    (vin[31]),
      .vsync    (vin[32]),
      .spare    (vin[34:33]),
      .pix_take (pix_take),
      .lane_out (lane_out),
      .clk_lane (clk_lane),
      .lane_oe  (lane_oe)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // behavioural reference
   int         m_cnt = 0;
   int         m_pos = 0;
   bit         m_oe  = 1'b0;
   logic [6:0] m_w [5];
   localparam logic [6:0] PAT = 7'b1100011;

   initial for (int i = 0; i < 5; i++) m_w[i] = '0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pos = 0; m_oe = 1'b0;
         for (int i = 0; i < 5; i++) m_w[i] = '0;
      end else if (m_cnt == 0) begin
         // capture per R2..R6
         m_w[0] = {vin[14], vin[9:4]};
         m_w[1] = {vin[25:24], vin[19:15]};
         m_w[2] = {vin[30], vin[32], vin[31], vin[29:26]};
         m_w[3] = {vin[33], vin[23:22], vin[13:12], vin[3:2]};
         m_w[4] = {vin[34], vin[21:20], vin[11:10], vin[1:0]};
         m_oe = 1'b1; m_pos = 0; m_cnt = 1;
      end else begin
         m_pos = m_pos + 1;
         m_cnt = (m_cnt == 6) ? 0 : m_cnt + 1;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         string lt [5];
         lt[0] = "R2"; lt[1] = "R3"; lt[2] = "R4"; lt[3] = "R5"; lt[4] = "R6";
         check("R1 pix_take", pix_take, (m_cnt == 0 && rst_n));
         check("R10/R9 lane_oe", lane_oe, m_oe);
         check("R8/R9 clk_lane", clk_lane, m_oe ? PAT[6 - m_pos] : 1'b0);
         for (int i = 0; i < 5; i++)
            check($sformatf("%s/R7/R11 lane %0d slot %0d", lt[i], i, m_pos),
                  lane_out[i], m_oe ? m_w[i][6 - m_pos] : 1'b0);
      end
   end

   task automatic step(input int n, input bit rnd);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #3;
         if (rnd) vin = {$urandom, $urandom};
      end
   endtask

   initial begin
      step(4, 1);
      #0 rst_n = 1'b1;                 // release; first capture next edge (R1, R10)
      step(300, 1);                    // inputs change every cycle (R11)
      vin = '1;  step(14, 0);
      vin = '0;  step(14, 0);
      for (int b = 0; b < 35; b++) begin   // walking one over every input bit
         vin = 35'd1 << b;
         step(7, 0);
      end
      step(3, 1);
      rst_n = 1'b0;                    // power-down mid-frame (R9)
      step(3, 1);
      rst_n = 1'b1;
      step(200, 1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int c = 0; c < 200000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule